// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked list of operation descriptors held in memory and hands each one to a downstream engine as a single job. Software writes the byte address of the first descriptor and pulses a start input. The walker then reads the eight 32-bit words of the descriptor through a simple word-read port. It unpacks the 64-bit source and destination buffer addresses, the byte length, the operation code and the parameter set, and presents them to the engine. It then waits for the engine to report completion.

When a job finishes without error, the walker can raise a one-cycle interrupt event for that descriptor. It then either ends the chain or follows the 64-bit next pointer to the following descriptor. A misaligned descriptor address or a memory read error aborts the chain with the transfer error code 0x0B, and no job is dispatched for that descriptor. A non-zero status from the engine stops the chain after the failing job. In every error case the zero-based position of the failing descriptor in the chain is held for software.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, busy, mem_req, job_valid, desc_irq, chain_done and chain_err are low, and err_code and err_index are zero.
- R2: For a descriptor at byte address A, the walker issues exactly eight reads, one outstanding at a time, at A, A+4, ..., A+28 in ascending order, and only then raises job_valid. mem_addr stays stable while mem_req waits for mem_rvalid, and mem_req and job_valid are never high together.
- R3: While job_valid is high the job fields are held stable, with these mappings from descriptor word k (byte offset 4k). job_src is {word1, word0} and job_dst is {word3, word2}. job_len is word4[15:0], job_op is word4[23:16] and job_param is word4[31:24]. job_valid stays high until job_done.
- R4: After a job_done with job_code zero, desc_irq pulses for exactly one cycle if and only if bit 0 of word7 is set.
- R5: After a successful job whose word7 bit 1 is set, chain_done pulses once and busy falls. Otherwise the next descriptor is fetched from the address {word6, word5}.
- R6: A start address or next pointer whose low five bits are not zero produces a chain_err pulse with err_code 0x0B, and no read or job is issued for that descriptor.
- R7: A read returned with mem_rerr aborts the chain with chain_err and err_code 0x0B, and no job is dispatched for that descriptor.
- R8: A job_done with non-zero job_code ends the chain with chain_err, sets err_code to that job_code and raises no desc_irq for that descriptor.
- R9: err_index holds the zero-based chain position of the descriptor that failed. Both err_code and err_index keep their values until the next accepted start, which clears them to zero.
- R10: A start pulse while busy is high is ignored, and the running chain continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| first_addr | input | 64 | Byte address of the first descriptor |
| busy | output | 1 | Chain in progress |
| mem_req | output | 1 | Word read request, held until mem_rvalid |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries an error |
| job_valid | output | 1 | Job fields valid, engine working |
| job_src | output | 64 | Source buffer address |
| job_dst | output | 64 | Destination buffer address |
| job_len | output | 16 | Source length in bytes |
| job_op | output | 8 | Operation code |
| job_param | output | 8 | Parameter set |
| job_done | input | 1 | Engine finished the current job |
| job_code | input | 8 | Engine status with job_done, zero for success |
| desc_irq | output | 1 | One-cycle per-descriptor completion event |
| chain_done | output | 1 | One-cycle pulse when the last descriptor completes |
| chain_err | output | 1 | One-cycle pulse when the chain aborts |
| err_code | output | 8 | Error code of the last abort |
| err_index | output | IDX_W | Chain position of the failing descriptor |

## Verification
On every cycle the assertions check the memory port handshake rules: the address is held while a read is pending, and reads never overlap a running job. They also check that job fields hold until completion, that desc_irq is never longer than one cycle, and that chain_done or chain_err coincide with the walker going idle. Only the bench scenarios can show the content-dependent behaviour: the word order of each fetch, the field unpacking, the choice between following the next pointer and ending the chain, and which descriptor index and code are reported for each of the three abort causes. They also show that a start pulse during a running chain changes nothing.

// File: rtl/sg_chain_walker.sv
module sg_chain_walker #(
  parameter int IDX_W    = 16,
  parameter int XFER_ERR = 8'h0B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      first_addr,
  output logic             busy,
  output logic             mem_req,
  output logic [63:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_rerr,
  output logic             job_valid,
  output logic [63:0]      job_src,
  output logic [63:0]      job_dst,
  output logic [15:0]      job_len,
  output logic [7:0]       job_op,
  output logic [7:0]       job_param,
  input  logic             job_done,
  input  logic [7:0]       job_code,
  output logic             desc_irq,
  output logic             chain_done,
  output logic             chain_err,
  output logic [7:0]       err_code,
  output logic [IDX_W-1:0] err_index
);
  localparam int NWORDS = 8;
  localparam int WC_W   = $clog2(NWORDS);
  localparam int ALIGN  = $clog2(NWORDS * 4);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} st_t;

  st_t              st;
  logic [63:0]      base;
  logic [WC_W-1:0]  wcnt;
  logic [31:0]      dw [NWORDS];
  logic [IDX_W-1:0] idx;
  logic [63:0]      nxt;

  assign nxt       = {dw[6], dw[5]};
  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_FETCH);
  assign job_valid = (st == S_EXEC);
  assign mem_addr  = base + 64'({wcnt, 2'b00});
  assign job_src   = {dw[1], dw[0]};
  assign job_dst   = {dw[3], dw[2]};
  assign job_len   = dw[4][15:0];
  assign job_op    = dw[4][23:16];
  assign job_param = dw[4][31:24];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      base       <= '0;
      wcnt       <= '0;
      idx        <= '0;
      desc_irq   <= 1'b0;
      chain_done <= 1'b0;
      chain_err  <= 1'b0;
      err_code   <= '0;
      err_index  <= '0;
      for (int i = 0; i < NWORDS; i++) dw[i] <= '0;
    end else begin
      desc_irq   <= 1'b0;
      chain_done <= 1'b0;
      chain_err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx       <= '0;
          err_code  <= '0;
          err_index <= '0;
          base      <= first_addr;
          wcnt      <= '0;
          if (first_addr[ALIGN-1:0] != '0) begin
            chain_err <= 1'b1;
            err_code  <= 8'(XFER_ERR);
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (mem_rvalid) begin
          if (mem_rerr) begin
            chain_err <= 1'b1;
            err_code  <= 8'(XFER_ERR);
            err_index <= idx;
            st        <= S_IDLE;
          end else begin
            dw[wcnt] <= mem_rdata;
            wcnt     <= wcnt + 1'b1;
            if (wcnt == WC_W'(NWORDS - 1)) st <= S_EXEC;
          end
        end
        S_EXEC: if (job_done) begin
          if (job_code != '0) begin
            chain_err <= 1'b1;
            err_code  <= job_code;
            err_index <= idx;
            st        <= S_IDLE;
          end else begin
            desc_irq <= dw[7][0];
            if (dw[7][1]) begin
              chain_done <= 1'b1;
              st         <= S_IDLE;
            end else if (nxt[ALIGN-1:0] != '0) begin
              chain_err <= 1'b1;
              err_code  <= 8'(XFER_ERR);
              err_index <= idx + 1'b1;
              st        <= S_IDLE;
            end else begin
              base <= nxt;
              idx  <= idx + 1'b1;
              wcnt <= '0;
              st   <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_chain_walker_chk.sv
module sg_chain_walker_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic [63:0]      mem_addr,
  input logic             mem_rvalid,
  input logic             job_valid,
  input logic [63:0]      job_src,
  input logic [63:0]      job_dst,
  input logic [15:0]      job_len,
  input logic [7:0]       job_op,
  input logic [7:0]       job_param,
  input logic             job_done,
  input logic             desc_irq,
  input logic             chain_done,
  input logic             chain_err,
  input logic [7:0]       err_code
);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && job_valid));

  // R3
  job_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_done |=> job_valid && $stable(job_src) && $stable(job_dst)
      && $stable(job_len) && $stable(job_op) && $stable(job_param));

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_irq |=> !desc_irq);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy && !chain_err);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_err |-> !busy && (err_code != 8'h00));
endmodule

bind sg_chain_walker sg_chain_walker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .job_valid(job_valid), .job_src(job_src),
  .job_dst(job_dst), .job_len(job_len), .job_op(job_op), .job_param(job_param),
  .job_done(job_done), .desc_irq(desc_irq), .chain_done(chain_done),
  .chain_err(chain_err), .err_code(err_code)
);

// File: tb/sg_chain_walker_test.sv
module sg_chain_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] first_addr = '0;
  logic        busy, mem_req, job_valid, desc_irq, chain_done, chain_err;
  logic [63:0] mem_addr, job_src, job_dst;
  logic        mem_rvalid = 1'b0, mem_rerr = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] job_len;
  logic [7:0]  job_op, job_param, err_code;
  logic        job_done = 1'b0;
  logic [7:0]  job_code = '0;
  logic [15:0] err_index;

  always #4 clk = ~clk;

  sg_chain_walker uut (.*);

  int ntests = 0, nfail = 0;
  logic [31:0] mem [0:255];
  logic [63:0] err_addr = '1;
  int fail_idx = -1;
  logic [7:0] fail_code = '0;

  int njobs, nirq, ndone, nerr, nrd, rd_before_job, eng_cnt;
  logic [63:0] rd_log [0:63];
  logic [7:0]  op_log [0:15];
  logic [63:0] src_log [0:15];
  logic [63:0] dst_log [0:15];
  logic [15:0] len_log [0:15];
  logic [7:0]  prm_log [0:15];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid = 1'b0;
      mem_rerr   = 1'b0;
    end else if (mem_req) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem[mem_addr[9:2]];
      mem_rerr   = (mem_addr == err_addr);
      if (nrd < 64) rd_log[nrd] = mem_addr;
      nrd++;
    end
  end

  always @(negedge clk) begin
    if (job_done) begin
      job_done = 1'b0;
      job_code = '0;
    end else if (job_valid) begin
      if (njobs == 0 && eng_cnt == 0 && rd_before_job < 0) rd_before_job = nrd;
      if (eng_cnt == 2) begin
        job_done = 1'b1;
        job_code = (njobs == fail_idx) ? fail_code : 8'h00;
        if (njobs < 16) begin
          op_log[njobs]  = job_op;
          src_log[njobs] = job_src;
          dst_log[njobs] = job_dst;
          len_log[njobs] = job_len;
          prm_log[njobs] = job_param;
        end
        njobs++;
        eng_cnt = 0;
      end else eng_cnt++;
    end
  end

  always @(negedge clk) begin
    if (desc_irq)   nirq++;
    if (chain_done) ndone++;
    if (chain_err)  nerr++;
  end

  task automatic put_desc(input int a, input logic [63:0] src, input logic [63:0] dst,
                          input logic [15:0] len, input logic [7:0] op, input logic [7:0] prm,
                          input logic [63:0] nxt, input logic [1:0] flags);
    int w = a / 4;
    mem[w]   = src[31:0];
    mem[w+1] = src[63:32];
    mem[w+2] = dst[31:0];
    mem[w+3] = dst[63:32];
    mem[w+4] = {prm, op, len};
    mem[w+5] = nxt[31:0];
    mem[w+6] = nxt[63:32];
    mem[w+7] = {30'h3ABCDEF0, flags};
  endtask

  task automatic run_chain(input logic [63:0] a);
    njobs = 0; nirq = 0; ndone = 0; nerr = 0; nrd = 0; rd_before_job = -1; eng_cnt = 0;
    @(negedge clk);
    first_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 job_valid", job_valid, 0);
    chk("R1 pulses", {desc_irq, chain_done, chain_err}, 0);
    chk("R1 err_code", err_code, 0);
    chk("R1 err_index", err_index, 0);
  endtask

  task automatic t_single;
    put_desc(32'h100, 64'h11112222_33334444, 64'h55556666_77778888, 16'd1184, 8'h02, 8'h03, 64'h0, 2'b11);
    run_chain(64'h100);
    chk("R2 reads before job", rd_before_job, 8);
    for (int k = 0; k < 8; k++) chk("R2 read order", rd_log[k], 64'h100 + 64'(4 * k));
    chk("R3 jobs", njobs, 1);
    chk("R3 src", src_log[0], 64'h11112222_33334444);
    chk("R3 dst", dst_log[0], 64'h55556666_77778888);
    chk("R3 len", len_log[0], 16'd1184);
    chk("R3 op", op_log[0], 8'h02);
    chk("R3 param", prm_log[0], 8'h03);
    chk("R4 irq count", nirq, 1);
    chk("R5 done count", ndone, 1);
    chk("R5 busy low", busy, 0);
    chk("R5 no err", nerr, 0);
  endtask

  task automatic build_chain3(input logic [1:0] fb);
    put_desc(32'h040, 64'hA0, 64'hA8, 16'd10, 8'h10, 8'h01, 64'h080, 2'b00);
    put_desc(32'h080, 64'hB0, 64'hB8, 16'd20, 8'h11, 8'h02, 64'h0C0, fb);
    put_desc(32'h0C0, 64'hC0, 64'hC8, 16'd30, 8'h06, 8'h03, 64'h0, 2'b10);
  endtask

  task automatic t_chain3;
    build_chain3(2'b01);
    run_chain(64'h040);
    chk("R5 chain jobs", njobs, 3);
    chk("R5 op 0", op_log[0], 8'h10);
    chk("R5 op 1", op_log[1], 8'h11);
    chk("R5 op 2", op_log[2], 8'h06);
    chk("R2 second fetch addr", rd_log[8], 64'h080);
    chk("R2 total reads", nrd, 24);
    chk("R4 only flagged irq", nirq, 1);
    chk("R5 one done", ndone, 1);
  endtask

  task automatic t_misalign_start;
    run_chain(64'h044);
    chk("R6 err pulse", nerr, 1);
    chk("R6 code", err_code, 8'h0B);
    chk("R6 no reads", nrd, 0);
    chk("R6 no job", njobs, 0);
    chk("R9 index", err_index, 0);
  endtask

  task automatic t_misalign_next;
    put_desc(32'h040, 64'hA0, 64'hA8, 16'd10, 8'h10, 8'h01, 64'h088, 2'b00);
    run_chain(64'h040);
    chk("R6 next jobs", njobs, 1);
    chk("R6 next err", nerr, 1);
    chk("R6 next code", err_code, 8'h0B);
    chk("R6 next reads", nrd, 8);
    chk("R9 next index", err_index, 1);
    chk("R6 no done", ndone, 0);
  endtask

  task automatic t_rd_err;
    build_chain3(2'b01);
    err_addr = 64'h08C;
    run_chain(64'h040);
    err_addr = '1;
    chk("R7 jobs", njobs, 1);
    chk("R7 err", nerr, 1);
    chk("R7 code", err_code, 8'h0B);
    chk("R7 reads", nrd, 12);
    chk("R9 rd index", err_index, 1);
  endtask

  task automatic t_eng_err;
    build_chain3(2'b01);
    fail_idx = 1;
    fail_code = 8'h04;
    run_chain(64'h040);
    fail_idx = -1;
    chk("R8 jobs", njobs, 2);
    chk("R8 code", err_code, 8'h04);
    chk("R8 no irq", nirq, 0);
    chk("R8 no done", ndone, 0);
    chk("R9 eng index", err_index, 1);
    repeat (5) @(negedge clk);
    chk("R9 held code", err_code, 8'h04);
  endtask

  task automatic t_clear;
    put_desc(32'h100, 64'h1, 64'h2, 16'd4, 8'h05, 8'h00, 64'h0, 2'b10);
    run_chain(64'h100);
    chk("R9 cleared code", err_code, 0);
    chk("R9 cleared index", err_index, 0);
    chk("R9 done", ndone, 1);
  endtask

  task automatic t_busy_start;
    build_chain3(2'b00);
    put_desc(32'h100, 64'h1, 64'h2, 16'd4, 8'h77, 8'h00, 64'h0, 2'b10);
    njobs = 0; nirq = 0; ndone = 0; nerr = 0; nrd = 0; rd_before_job = -1; eng_cnt = 0;
    @(negedge clk);
    first_addr = 64'h040;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    first_addr = 64'h100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 jobs", njobs, 3);
    chk("R10 op 0", op_log[0], 8'h10);
    chk("R10 op 2", op_log[2], 8'h06);
    chk("R10 done", ndone, 1);
    chk("R10 no err", nerr, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    njobs = 0; nirq = 0; ndone = 0; nerr = 0; nrd = 0; rd_before_job = -1; eng_cnt = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single;
    t_chain3;
    t_misalign_start;
    t_misalign_next;
    t_rd_err;
    t_eng_err;
    t_clear;
    t_busy_start;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule